// File: doc/BRIEF.md
# Current-mode PWM gating logic

This block is the digital heart of a current-mode switching regulator. It receives a one-cycle oscillator tick, a peak-current comparator flag, an over-current flag, a supply-good flag and two active-low control pins: `stop_n` (shutdown) and `rearm_n` (latch release). From these it produces one gate-drive enable. Every analog function is modelled as a synchronous digital input, sampled on the rising edge of `clk`.

Oscillator ticks are counted in pairs to form the switching period. A period begins on an even tick, where the output turns on if operation is permitted and no trip is present. The output turns off on the first trip or on the odd tick that marks mid-period. This caps the duty cycle at one half.

Operation is permitted only while the supply-good flag is high, `stop_n` is high and the hold latch is open. The latch closes when both control pins are low together. It then ignores `stop_n` until `rearm_n` goes high. Both control pins pass through a two-flop synchronizer that resets to high.

The pulse sequencer has three states:
- `PH_IDLE`: off, entered on mid-period.
- `PH_ON`: output high.
- `PH_SPENT`: off for the remainder of a period that was cut short or refused.

Its transitions are:
- *launch*: `PH_IDLE` or `PH_SPENT` to `PH_ON`, on a period start with permission and no trip.
- *refuse*: `PH_IDLE` to `PH_SPENT`, on a period start without permission or with a trip.
- *cut*: `PH_ON` to `PH_SPENT`, on a trip or loss of permission.
- *half*: `PH_ON` or `PH_SPENT` to `PH_IDLE`, on the mid-period tick.

The hold latch has two states, `LT_OPEN` and `LT_HELD`. Its transitions are:
- *arm*: `LT_OPEN` to `LT_HELD`, when both synchronized pins are low.
- *release*: `LT_HELD` to `LT_OPEN`, when the synchronized `rearm_n` is high.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: The tick counter resets to zero; the first tick after reset and every second tick after it start a period, and the other ticks are mid-period.
- R2: At a period start with permission and no trip, `gate_en` is high after that edge.
- R3: `cm_trip` high while `gate_en` is high drives `gate_en` low after the next edge, and it stays low until the next period start.
- R4: `oc_trip` has the same effect as `cm_trip`, independently of it.
- R5: The mid-period tick drives `gate_en` low after that edge, so the output is never high across more than half a period.
- R6: `uv_good` low at an edge drives `gate_en` low after that edge; a period start seen with `uv_good` low gives no pulse in that period.
- R7: With `rearm_n` high, `stop_n` low turns the output off without latching, and pulses resume at the first period start after `stop_n` is back high.
- R8: When both synchronized pins are low, the hold latch closes and the output stays off whatever `stop_n` does afterwards.
- R9: With `stop_n` high and `rearm_n` low, the hold latch keeps its state.
- R10: With `rearm_n` high, the latch opens; if `stop_n` is also high, pulses resume at the next period start.
- R11: Both pins are synchronized through two flops that reset to high; a level set up before edge n acts on `gate_en` after edge n+2.
- R12: `rst` high at an edge clears the tick counter, the sequencer and the hold latch, and it forces `gate_en` low after that edge.
- R13: A trip present at a period start prevents any pulse in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| cm_trip | input | 1 | Peak-current comparator flag, active high |
| oc_trip | input | 1 | Over-current flag, active high |
| uv_good | input | 1 | Supply above the lockout threshold, active high |
| stop_n | input | 1 | Asynchronous shutdown pin, active low |
| rearm_n | input | 1 | Asynchronous latch-release pin, active low |
| gate_en | output | 1 | Gate-drive enable |

## Verification
The bench builds the block with its defaults: `OSC_DIV` = 2 ticks per period and `SYNC_STAGES` = 2. With these values, a period is four clocks when ticks arrive every second cycle. The bench can therefore predict every cycle by hand, including the two-edge pin latency.

With the short period, a compact vector table reaches every truth-table row of the control pins, a latch release while shutdown is still low, and trips both at launch and mid-pulse. Directed steps then confirm that reset clears the tick parity and the hold latch.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ON    = 2'd1,
        PH_SPENT = 2'd2
    } pwm_phase_e;

    typedef enum logic {
        LT_OPEN = 1'b0,
        LT_HELD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/pwm_period_div.sv
module pwm_period_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    output logic period_start,
    output logic period_mid
);

    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (osc_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign period_start = osc_tick && (cnt == '0);
    assign period_mid   = osc_tick && (cnt == HALF);

endmodule

// File: rtl/pwm_hold_latch.sv
module pwm_hold_latch
    import pwm_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_s,
    input  logic rearm_s,
    output logic held
);

    hold_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= LT_OPEN;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LT_OPEN: if (!stop_s && !rearm_s) nxt = LT_HELD;
            LT_HELD: if (rearm_s)             nxt = LT_OPEN;
            default:                          nxt = LT_OPEN;
        endcase
    end

    always_comb held = (state == LT_HELD);

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
    import pwm_gate_pkg::*;
#(
    parameter int OSC_DIV     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic cm_trip,
    input  logic oc_trip,
    input  logic uv_good,
    input  logic stop_n,
    input  logic rearm_n,
    output logic gate_en
);

    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pins_raw, pins_s;
    logic stop_s, rearm_s, latch_on;
    logic period_start, period_mid;
    logic permit, trip;

    assign pins_raw = {stop_n, rearm_n};

    pwm_sync2 #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PIN_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (pins_raw),
        .d_out(pins_s)
    );

    assign stop_s  = pins_s[1];
    assign rearm_s = pins_s[0];

    pwm_hold_latch u_hold (
        .clk    (clk),
        .rst    (rst),
        .stop_s (stop_s),
        .rearm_s(rearm_s),
        .held   (latch_on)
    );

    pwm_period_div #(.DIV(OSC_DIV)) u_div (
        .clk         (clk),
        .rst         (rst),
        .osc_tick    (osc_tick),
        .period_start(period_start),
        .period_mid  (period_mid)
    );

    assign permit = uv_good && stop_s && !latch_on;
    assign trip   = cm_trip || oc_trip;

    pwm_phase_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= PH_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE: begin
                if (period_start)
                    nxt = (permit && !trip) ? PH_ON : PH_SPENT;
            end
            PH_ON: begin
                if (!permit || trip) nxt = PH_SPENT;
                else if (period_mid) nxt = PH_IDLE;
            end
            PH_SPENT: begin
                if (period_start)
                    nxt = (permit && !trip) ? PH_ON : PH_SPENT;
                else if (period_mid)
                    nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_comb gate_en = (state == PH_ON);

endmodule

// File: rtl/pwm_gate_chk.sv
module pwm_gate_chk (
    input logic clk,
    input logic rst,
    input logic cm_trip,
    input logic oc_trip,
    input logic uv_good,
    input logic stop_s,
    input logic rearm_s,
    input logic latch_on,
    input logic period_start,
    input logic period_mid,
    input logic gate_en
);

    // R2
    launch_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_en) |-> $past(period_start));

    // R3
    cm_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && cm_trip) |=> !gate_en);

    // R4
    oc_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && oc_trip) |=> !gate_en);

    // R5
    mid_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && period_mid) |=> !gate_en);

    // R6
    uv_block_chk: assert property (@(posedge clk) disable iff (rst)
        !uv_good |=> !gate_en);

    // R7
    stop_block_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_s |=> !gate_en);

    // R8
    latch_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop_s && !rearm_s) |=> latch_on);

    // R8
    latch_block_chk: assert property (@(posedge clk) disable iff (rst)
        latch_on |=> !gate_en);

    // R9
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_s && !rearm_s) |=> $stable(latch_on));

    // R10
    latch_open_chk: assert property (@(posedge clk) disable iff (rst)
        rearm_s |=> !latch_on);

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!gate_en && !latch_on));

endmodule

bind pwm_gate_ctrl pwm_gate_chk u_gate_chk (
    .clk         (clk),
    .rst         (rst),
    .cm_trip     (cm_trip),
    .oc_trip     (oc_trip),
    .uv_good     (uv_good),
    .stop_s      (stop_s),
    .rearm_s     (rearm_s),
    .latch_on    (latch_on),
    .period_start(period_start),
    .period_mid  (period_mid),
    .gate_en     (gate_en)
);

// File: tb/test_pwm_gate_ctrl.sv
module test_pwm_gate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 64;
    localparam int WATCHDOG   = 5000;

    // {osc, cm, oc, uv, stop_n, rearm_n, expected gate_en after the edge}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_1_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_1_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_1_0_1_1_1_0, 7'b0_0_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_0_1_1_0, 7'b0_0_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_0_1_1_0, 7'b1_0_0_1_0_1_0, 7'b0_0_0_1_0_1_0,
        7'b1_0_0_1_0_1_0, 7'b0_0_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_0_1_0,
        7'b1_0_0_1_0_1_1, 7'b0_0_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_0_0_0, 7'b0_0_0_1_0_0_0,
        7'b1_0_0_1_1_0_0, 7'b0_0_0_1_1_0_0, 7'b1_0_0_1_1_0_0, 7'b0_0_0_1_1_0_0,
        7'b1_0_0_1_1_0_0, 7'b0_0_0_1_1_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_0_0_0, 7'b0_0_0_1_0_0_0,
        7'b1_0_0_1_0_1_0, 7'b0_0_0_1_0_1_0, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0,
        7'b1_0_0_1_1_1_1, 7'b0_0_0_1_1_1_1, 7'b1_0_0_1_1_1_0, 7'b0_0_0_1_1_1_0
    };

    logic clk = 1'b0;
    logic rst, osc_tick, cm_trip, oc_trip, uv_good, stop_n, rearm_n;
    logic gate_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_gate_ctrl i_pwm_gate_ctrl (
        .clk     (clk),
        .rst     (rst),
        .osc_tick(osc_tick),
        .cm_trip (cm_trip),
        .oc_trip (oc_trip),
        .uv_good (uv_good),
        .stop_n  (stop_n),
        .rearm_n (rearm_n),
        .gate_en (gate_en)
    );

    task automatic drive(input logic o, input logic c, input logic x,
                         input logic u, input logic s, input logic r);
        osc_tick = o; cm_trip = c; oc_trip = x;
        uv_good  = u; stop_n  = s; rearm_n = r;
    endtask

    task automatic check(input logic exp, input string req);
        checks++;
        if (gate_en !== exp) begin
            errors++;
            $display("FAIL %s: gate_en actual %b expected %b at %0t",
                     req, gate_en, exp, $time);
        end
    endtask

    function automatic string row_req(input int i);
        if (i < 8)       return "R1 R2 R5";
        else if (i < 12) return "R3";
        else if (i < 16) return "R4";
        else if (i < 20) return "R13";
        else if (i < 26) return "R6";
        else if (i < 36) return "R7 R11";
        else if (i < 42) return "R7";
        else if (i < 54) return "R8 R9 R10";
        else             return "R10";
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 1, 1, 1);

        // R12: output held low through reset even with ticks present
        for (int k = 0; k < 3; k++) begin
            osc_tick = k[0];
            @(negedge clk);
            check(1'b0, "R12 reset");
        end

        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            @(negedge clk);
            check(VEC[i][0], row_req(i));
        end

        // R1 R12: reset in the middle of a pulse clears the tick parity
        drive(1, 0, 0, 1, 1, 1);
        @(negedge clk); check(1'b1, "R2 launch");
        drive(0, 0, 0, 1, 1, 1); rst = 1'b1;
        @(negedge clk); check(1'b0, "R12 reset drops gate");
        rst = 1'b0;
        @(negedge clk); check(1'b0, "R12 idle after reset");
        drive(1, 0, 0, 1, 1, 1);
        @(negedge clk); check(1'b1, "R1 first tick after reset starts");
        drive(0, 0, 0, 1, 1, 1);
        @(negedge clk); check(1'b1, "R1 pulse held");

        // R12: reset opens a held latch
        drive(0, 0, 0, 1, 0, 0);
        repeat (3) @(negedge clk);
        drive(0, 0, 0, 1, 1, 0);
        repeat (3) @(negedge clk);
        check(1'b0, "R8 latch held");
        rst = 1'b1;
        @(negedge clk); check(1'b0, "R12 reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        drive(1, 0, 0, 1, 1, 0);
        @(negedge clk); check(1'b1, "R12 latch cleared by reset");
        drive(0, 0, 0, 1, 1, 0);
        @(negedge clk); check(1'b1, "R9 open latch stays open");

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule